// File: doc/BRIEF.md
# Narrow-to-Wide Memory-Mapped Width Upsizer

This block sits between a 32-bit memory-mapped master and a slave whose data path is wider (64 bits by default, any power of two up to 1024 bits). Every master transfer becomes exactly one slave transfer. The master byte address is split into two parts. The upper bits form the slave word address. The bits between the master word size and the slave word size pick which 32-bit lane group of the slave word the master reaches.

On a write, the master data is placed on every lane group of the slave data bus. The slave byteenables are raised only inside the selected group, so the slave updates only the addressed bytes. On a read, the block returns the selected 32-bit group of the slave word to the master.

The master and slave command signals pass through one register stage, so that all slave-side outputs come from flops. When the slave drops its waitrequest, the read data is captured. In the following cycle the master sees waitrequest low for a single cycle. A master transfer takes at least three cycles, plus any wait cycles the slave inserts. The master address port omits the two low byte-address bits, which are always zero for full-word master accesses.

Top module: `bus_upsizer`

## Requirements
- R1: While reset is high and in the first cycle after it, s_read and s_write are 0 and m_waitrequest is 1.
- R2: The slave word address equals the master byte address divided by the slave width in bytes. With a 64-bit slave, byte addresses 0x08 and 0x0C both reach slave word 1, and 0x14 reaches word 2.
- R3: The lane group g is the master byte address bits [log2(slave bytes)-1 : 2], which is bit 2 for a 64-bit slave. Slave byteenable bits [4g+3:4g] carry the master byteenables and all other slave byteenable bits are 0, on reads and on writes.
- R4: On a write, the master write data appears on slave data bits [32g+31:32g]. Slave bytes outside the enabled lanes keep their previous contents, so a later read returns their old values.
- R5: On a read, m_readdata returns slave readdata bits [32g+31:32g], sampled in the cycle in which the slave accepts the read.
- R6: Each master transfer produces exactly one slave transfer. While s_waitrequest is high, the slave command, address and byteenables stay asserted and unchanged.
- R7: m_waitrequest goes low for exactly one cycle, which is the cycle after the slave accepts the transfer, and stays high at all other times.
- R8: The slave command matches the master command: s_read for a master read, s_write for a master write. s_read and s_write are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_address | input | ADDR_W-2 (30) | Master byte address bits [ADDR_W-1:2] |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_byteenable | input | MST_DW/8 (4) | Master byte enables |
| m_writedata | input | MST_DW (32) | Master write data |
| m_readdata | output | MST_DW (32) | Read data returned to master |
| m_waitrequest | output | 1 | Low for one cycle when the transfer completes |
| s_address | output | ADDR_W-log2(SLV_DW/8) (29) | Slave word address |
| s_read | output | 1 | Slave read request |
| s_write | output | 1 | Slave write request |
| s_byteenable | output | SLV_DW/8 (8) | Slave byte enables |
| s_writedata | output | SLV_DW (64) | Slave write data |
| s_readdata | input | SLV_DW (64) | Slave read data, valid when s_waitrequest is low |
| s_waitrequest | input | 1 | Slave stall |

## Verification
The assertions assume the master follows the usual handshake. It holds its command steady until it sees waitrequest low, and it never raises read and write in the same cycle. The slave is assumed to return read data in the same cycle it lowers waitrequest. The bench master drives one command at a time and removes it right after the completion cycle. The bench slave model answers with zero-latency data and a programmable number of wait cycles, from zero upward.

// File: rtl/upsz_pkg.sv
package upsz_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_RESP  = 2'd2
  } upsz_state_e;

endpackage

// File: rtl/upsz_addr_map.sv
module upsz_addr_map #(
  parameter int ADDR_W = 32,
  parameter int MST_DW = 32,
  parameter int SLV_DW = 64
) (
  input  logic [ADDR_W-$clog2(MST_DW/8)-1:0] mst_word_addr,
  output logic [ADDR_W-$clog2(SLV_DW/8)-1:0] slv_word_addr,
  output logic [$clog2(SLV_DW/MST_DW)-1:0]   lane_grp
);
  localparam int MST_OFF = $clog2(MST_DW / 8);
  localparam int SLV_OFF = $clog2(SLV_DW / 8);
  localparam int GRP_W   = SLV_OFF - MST_OFF;
  localparam int MA_W    = ADDR_W - MST_OFF;

  // low bits of the master word address choose the lane group,
  // the rest is the slave word address
  assign lane_grp      = mst_word_addr[GRP_W-1:0];
  assign slv_word_addr = mst_word_addr[MA_W-1:GRP_W];

endmodule

// File: rtl/upsz_wr_steer.sv
module upsz_wr_steer #(
  parameter int MST_DW = 32,
  parameter int SLV_DW = 64
) (
  input  logic [$clog2(SLV_DW/MST_DW)-1:0] lane_grp,
  input  logic [MST_DW/8-1:0]              mst_be,
  input  logic [MST_DW-1:0]                mst_wdata,
  output logic [SLV_DW/8-1:0]              slv_be,
  output logic [SLV_DW-1:0]                slv_wdata
);
  localparam int RATIO = SLV_DW / MST_DW;
  localparam int MBE_W = MST_DW / 8;
  localparam int GRP_W = $clog2(RATIO);

  for (genvar g = 0; g < RATIO; g++) begin : g_lane
    // data is copied to every group; the byteenables pick the real target
    assign slv_wdata[g*MST_DW +: MST_DW] = mst_wdata;
    assign slv_be[g*MBE_W +: MBE_W] =
      (lane_grp == GRP_W'(g)) ? mst_be : '0;
  end

endmodule

// File: rtl/upsz_rd_select.sv
module upsz_rd_select #(
  parameter int MST_DW = 32,
  parameter int SLV_DW = 64
) (
  input  logic [$clog2(SLV_DW/MST_DW)-1:0] lane_grp,
  input  logic [SLV_DW-1:0]                slv_rdata,
  output logic [MST_DW-1:0]                mst_rdata
);
  localparam int RATIO = SLV_DW / MST_DW;
  localparam int GRP_W = $clog2(RATIO);

  always_comb begin
    mst_rdata = '0;
    for (int g = 0; g < RATIO; g++) begin
      if (lane_grp == GRP_W'(g)) mst_rdata = slv_rdata[g*MST_DW +: MST_DW];
    end
  end

endmodule

// File: rtl/bus_upsizer.sv
module bus_upsizer #(
  parameter int ADDR_W = 32,
  parameter int MST_DW = 32,
  parameter int SLV_DW = 64
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [ADDR_W-$clog2(MST_DW/8)-1:0]  m_address,
  input  logic                                m_read,
  input  logic                                m_write,
  input  logic [MST_DW/8-1:0]                 m_byteenable,
  input  logic [MST_DW-1:0]                   m_writedata,
  output logic [MST_DW-1:0]                   m_readdata,
  output logic                                m_waitrequest,
  output logic [ADDR_W-$clog2(SLV_DW/8)-1:0]  s_address,
  output logic                                s_read,
  output logic                                s_write,
  output logic [SLV_DW/8-1:0]                 s_byteenable,
  output logic [SLV_DW-1:0]                   s_writedata,
  input  logic [SLV_DW-1:0]                   s_readdata,
  input  logic                                s_waitrequest
);
  import upsz_pkg::*;

  localparam int RATIO = SLV_DW / MST_DW;
  localparam int GRP_W = $clog2(RATIO);
  localparam int SWA_W = ADDR_W - $clog2(SLV_DW / 8);
  localparam int SBE_W = SLV_DW / 8;

  upsz_state_e        state;
  logic [SWA_W-1:0]   map_addr;
  logic [GRP_W-1:0]   map_grp;
  logic [SBE_W-1:0]   steer_be;
  logic [SLV_DW-1:0]  steer_wd;
  logic [MST_DW-1:0]  pick_rd;

  logic [SWA_W-1:0]   addr_q;
  logic [GRP_W-1:0]   grp_q;
  logic [SBE_W-1:0]   be_q;
  logic [SLV_DW-1:0]  wd_q;
  logic [MST_DW-1:0]  rd_q;
  logic               srd_q;
  logic               swr_q;
  logic               wait_q;

  upsz_addr_map #(.ADDR_W(ADDR_W), .MST_DW(MST_DW), .SLV_DW(SLV_DW)) u_map (
    .mst_word_addr (m_address),
    .slv_word_addr (map_addr),
    .lane_grp      (map_grp)
  );

  upsz_wr_steer #(.MST_DW(MST_DW), .SLV_DW(SLV_DW)) u_steer (
    .lane_grp  (map_grp),
    .mst_be    (m_byteenable),
    .mst_wdata (m_writedata),
    .slv_be    (steer_be),
    .slv_wdata (steer_wd)
  );

  upsz_rd_select #(.MST_DW(MST_DW), .SLV_DW(SLV_DW)) u_rsel (
    .lane_grp  (grp_q),
    .slv_rdata (s_readdata),
    .mst_rdata (pick_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      srd_q  <= 1'b0;
      swr_q  <= 1'b0;
      wait_q <= 1'b1;
      addr_q <= '0;
      grp_q  <= '0;
      be_q   <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (m_read || m_write) begin
            srd_q  <= m_read;
            swr_q  <= m_write && !m_read;
            addr_q <= map_addr;
            grp_q  <= map_grp;
            be_q   <= steer_be;
            wd_q   <= steer_wd;
            state  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (!s_waitrequest) begin
            srd_q  <= 1'b0;
            swr_q  <= 1'b0;
            wait_q <= 1'b0;
            if (srd_q) rd_q <= pick_rd;
            state  <= ST_RESP;
          end
        end
        ST_RESP: begin
          wait_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign s_address     = addr_q;
  assign s_read        = srd_q;
  assign s_write       = swr_q;
  assign s_byteenable  = be_q;
  assign s_writedata   = wd_q;
  assign m_readdata    = rd_q;
  assign m_waitrequest = wait_q;

endmodule

// File: rtl/upsz_checker.sv
module upsz_checker #(
  parameter int ADDR_W = 32,
  parameter int MST_DW = 32,
  parameter int SLV_DW = 64
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                m_waitrequest,
  input logic [ADDR_W-$clog2(SLV_DW/8)-1:0]  s_address,
  input logic                                s_read,
  input logic                                s_write,
  input logic [SLV_DW/8-1:0]                 s_byteenable,
  input logic                                s_waitrequest
);
  localparam int RATIO = SLV_DW / MST_DW;
  localparam int MBE_W = MST_DW / 8;

  logic [RATIO-1:0] grp_live;
  logic             s_cmd;

  for (genvar g = 0; g < RATIO; g++) begin : g_live
    assign grp_live[g] = |s_byteenable[g*MBE_W +: MBE_W];
  end
  assign s_cmd = s_read || s_write;

  initial begin
    assert (SLV_DW > MST_DW && (SLV_DW % MST_DW) == 0 && SLV_DW <= 1024)
      else $error("slave width must be a wider power-of-two multiple");
  end

  assert_cmd_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(s_read && s_write));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (s_cmd && s_waitrequest) |=>
      (s_cmd && $stable(s_address) && $stable(s_byteenable) &&
       $stable(s_read)));

  assert_single_R6: assert property (@(posedge clk) disable iff (rst)
    (s_cmd && !s_waitrequest) |=> !s_cmd);

  assert_resp_R7: assert property (@(posedge clk) disable iff (rst)
    (s_cmd && !s_waitrequest) |=> !m_waitrequest);

  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    !m_waitrequest |=> m_waitrequest);

  assert_no_resp_busy_R7: assert property (@(posedge clk) disable iff (rst)
    s_cmd |-> m_waitrequest);

  assert_one_group_R3: assert property (@(posedge clk) disable iff (rst)
    s_cmd |-> $onehot0(grp_live));

endmodule

bind bus_upsizer upsz_checker #(
  .ADDR_W (ADDR_W),
  .MST_DW (MST_DW),
  .SLV_DW (SLV_DW)
) u_upsz_checker (
  .clk           (clk),
  .rst           (rst),
  .m_waitrequest (m_waitrequest),
  .s_address     (s_address),
  .s_read        (s_read),
  .s_write       (s_write),
  .s_byteenable  (s_byteenable),
  .s_waitrequest (s_waitrequest)
);

// File: tb/bus_upsizer_bench.sv
module bus_upsizer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int MST_DW = 32;
  localparam int SLV_DW = 64;
  localparam int MA_W   = ADDR_W - 2;
  localparam int SWA_W  = ADDR_W - 3;
  localparam int DEPTH  = 16;

  typedef struct {
    bit          rd;
    int          saddr;
    int          grp;
    logic [7:0]  be;
    logic [31:0] wd;
    logic [31:0] rdata;
  } item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [MA_W-1:0]   m_address = '0;
  logic              m_read = 1'b0;
  logic              m_write = 1'b0;
  logic [3:0]        m_byteenable = '0;
  logic [31:0]       m_writedata = '0;
  logic [31:0]       m_readdata;
  logic              m_waitrequest;
  logic [SWA_W-1:0]  s_address;
  logic              s_read;
  logic              s_write;
  logic [7:0]        s_byteenable;
  logic [63:0]       s_writedata;
  logic [63:0]       s_readdata;
  logic              s_waitrequest;

  int          n_tests = 0;
  int          n_fail  = 0;
  int          cyc     = 0;
  int          acc_cyc = -10;
  int          acc_cnt = 0;
  int          wait_cycles = 0;
  int          stall_cnt = 0;
  bit          finished = 1'b0;
  logic [63:0] mem    [DEPTH];
  logic [63:0] shadow [DEPTH];
  item_t       q[$];

  bus_upsizer #(.ADDR_W(ADDR_W), .MST_DW(MST_DW), .SLV_DW(SLV_DW)) u_bus_upsizer (
    .clk (clk), .rst (rst),
    .m_address (m_address), .m_read (m_read), .m_write (m_write),
    .m_byteenable (m_byteenable), .m_writedata (m_writedata),
    .m_readdata (m_readdata), .m_waitrequest (m_waitrequest),
    .s_address (s_address), .s_read (s_read), .s_write (s_write),
    .s_byteenable (s_byteenable), .s_writedata (s_writedata),
    .s_readdata (s_readdata), .s_waitrequest (s_waitrequest)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // slave model: zero-latency data, programmable stall
  assign s_waitrequest = (s_read || s_write) && (stall_cnt < wait_cycles);
  assign s_readdata    = mem[s_address[3:0]];

  always @(posedge clk) begin
    if ((s_read || s_write) && s_waitrequest) stall_cnt <= stall_cnt + 1;
    else stall_cnt <= 0;
    if (s_write && !s_waitrequest)
      for (int b = 0; b < 8; b++)
        if (s_byteenable[b]) mem[s_address[3:0]][b*8 +: 8] <= s_writedata[b*8 +: 8];
  end

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // slave-side monitor
  always @(negedge clk) begin
    if (!rst && (s_read || s_write) && !s_waitrequest) begin
      acc_cnt++;
      acc_cyc = cyc;
      if (q.size() == 0) begin
        check(0, "R6", "slave transfer with nothing pending", 64'(s_address), 64'hx);
      end else begin
        check(s_read == q[0].rd && s_write == !q[0].rd, "R8", "slave command type",
              {62'd0, s_read, s_write}, {62'd0, q[0].rd, !q[0].rd});
        check(s_address == SWA_W'(q[0].saddr), "R2", "slave word address",
              64'(s_address), 64'(q[0].saddr));
        check(s_byteenable == q[0].be, "R3", "slave byteenables",
              64'(s_byteenable), 64'(q[0].be));
        if (!q[0].rd)
          check(s_writedata[q[0].grp*32 +: 32] == q[0].wd, "R4", "write lane data",
                64'(s_writedata[q[0].grp*32 +: 32]), 64'(q[0].wd));
      end
    end
  end

  // master-side monitor
  always @(negedge clk) begin
    if (!rst && !m_waitrequest) begin
      if (q.size() == 0) begin
        check(0, "R7", "completion with nothing pending", 64'd0, 64'd1);
      end else begin
        check(acc_cnt == 1, "R6", "slave transfers per master transfer",
              64'(acc_cnt), 64'd1);
        check(cyc == acc_cyc + 1, "R7", "completion cycle", 64'(cyc), 64'(acc_cyc + 1));
        if (q[0].rd)
          check(m_readdata == q[0].rdata, "R5", "read data", 64'(m_readdata),
                64'(q[0].rdata));
        void'(q.pop_front());
      end
      acc_cnt = 0;
    end
  end

  task automatic xfer(bit rd, int baddr, logic [3:0] be, logic [31:0] wd, int waits);
    item_t it;
    int idx;
    it.rd    = rd;
    it.saddr = baddr >> 3;
    it.grp   = (baddr >> 2) & 1;
    it.be    = 8'(be) << (it.grp * 4);
    it.wd    = wd;
    idx      = it.saddr % DEPTH;
    it.rdata = shadow[idx][it.grp*32 +: 32];
    if (!rd)
      for (int b = 0; b < 4; b++)
        if (be[b]) shadow[idx][it.grp*32 + b*8 +: 8] = wd[b*8 +: 8];
    q.push_back(it);
    wait_cycles = waits;
    @(negedge clk);
    m_address    = MA_W'(baddr >> 2);
    m_read       = rd;
    m_write      = !rd;
    m_byteenable = be;
    m_writedata  = wd;
    do @(negedge clk); while (m_waitrequest);
    @(posedge clk);
    #1;
    m_read  = 1'b0;
    m_write = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]    = {32'h5000_0000 + 32'(i), 32'hA000_0000 + 32'(i)};
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(!s_read && !s_write && m_waitrequest, "R1", "state in reset",
          {61'd0, s_read, s_write, m_waitrequest}, 64'd1);
    rst = 1'b0;
    @(negedge clk);
    check(!s_read && !s_write && m_waitrequest, "R1", "state after reset",
          {61'd0, s_read, s_write, m_waitrequest}, 64'd1);

    xfer(1, 'h00, 4'hF, '0, 0);            // R5 low group of word 0
    xfer(1, 'h04, 4'hF, '0, 0);            // R5 high group of word 0
    xfer(1, 'h0C, 4'hF, '0, 3);            // R2 word 1, stalled slave R6
    xfer(0, 'h08, 4'hF, 32'h1122_3344, 0); // R3 be 0x0F, R4
    xfer(0, 'h14, 4'h6, 32'hDEAD_BEEF, 2); // R3 be 0x60, partial write
    xfer(0, 'h24, 4'h1, 32'h0000_00AB, 1);
    xfer(1, 'h08, 4'hF, '0, 0);            // R4 written lanes
    xfer(1, 'h0C, 4'hF, '0, 0);            // R4 neighbour group untouched
    xfer(1, 'h14, 4'hF, '0, 1);            // R4 partial bytes kept
    xfer(1, 'h10, 4'hF, '0, 0);            // R4 low group of word 2 untouched
    xfer(1, 'h24, 4'h3, '0, 4);            // R3 be 0x30 on a read
    xfer(1, 'h78, 4'hF, '0, 0);            // R2 word 15
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R6", "pending items at end", 64'(q.size()), 64'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule